// File: doc/BRIEF.md
# UART Frame Transmitter

This block turns one parallel byte into an asynchronous serial frame on a single output line. A sender places a byte on the data input, sets the two parity controls, and pulses the valid strobe while the busy flag is low. The block captures the byte and the parity settings together on that cycle. It then drives a low start bit, the data bits least significant first, an optional parity bit and a high stop bit. Each bit lasts one clock cycle. In a larger design that clock would be a baud-rate enable.

The busy flag stays high for the whole frame. It drops only after the stop bit has been on the line for a full bit time. A new byte can therefore be accepted on the first cycle in which busy reads low. Parity can be enabled or disabled, and set to even or odd, separately for each frame.

Top module: `uart_frame_tx`

## Requirements
- R1: Reset is synchronous and active high. During reset and on the cycle after it, `tx_line` is 1 and `tx_busy` is 0. Whenever `tx_busy` is 0, `tx_line` is 1.
- R2: If `tx_valid` is 1 on a clock edge at which `tx_busy` is 0, the frame is accepted. `tx_busy` is 1 from the next cycle, and on that same cycle `tx_line` carries the start bit, value 0.
- R3: The DATA_W data bits follow the start bit, one per cycle, with bit 0 first.
- R4: If `par_on` was 1 at acceptance, a parity bit follows the last data bit. With `par_odd` = 0 (even), the number of ones across the data bits and the parity bit is even. With `par_odd` = 1 (odd), that number is odd.
- R5: If `par_on` was 0 at acceptance, no parity bit is sent, and the stop bit comes directly after the last data bit.
- R6: The stop bit is 1 and lasts exactly one cycle. `tx_busy` goes low on the cycle after it. `tx_busy` therefore stays high for DATA_W+3 cycles with parity and DATA_W+2 cycles without.
- R7: Changing `tx_data`, `par_on` or `par_odd` after acceptance does not alter the frame in flight.
- R8: A `tx_valid` pulse on an edge at which `tx_busy` is 1 is ignored. It starts no frame and changes no bit of the current frame.
- R9: A valid strobe on the first cycle that `tx_busy` is low starts the next frame immediately. This leaves exactly one idle-high cycle between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one bit per cycle |
| rst | input | 1 | Synchronous reset, active high |
| tx_data | input | DATA_W | Byte to send |
| par_on | input | 1 | 1 = append a parity bit |
| par_odd | input | 1 | Parity type: 0 even, 1 odd |
| tx_valid | input | 1 | Request to send the presented byte |
| tx_line | output | 1 | Serial output, idles high |
| tx_busy | output | 1 | High while a frame is in progress |

## Verification
The bound checker watches several properties on every cycle. It checks the line level while idle and after reset, that the start bit appears as busy rises, that the stop bit is high in the last busy cycle, and that acceptance raises busy on the next cycle. It also checks that the length of each busy window matches the parity setting latched at acceptance. The assertions do not look at bit values. LSB-first ordering, the even and odd parity values, and the immunity of a frame to input changes or extra strobes can only be shown by the scoreboard, which compares every line bit against a frame built independently.

// File: rtl/uftx_pkg.sv
package uftx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } tx_state_e;
endpackage

// File: rtl/uftx_parity.sv
module uftx_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              odd,
    output logic              bit_out
);
    // Even: the bit equals the XOR of the data. Odd: that value inverted.
    always_comb begin
        bit_out = (^data) ^ odd;
    end
endmodule

// File: rtl/uftx_core.sv
module uftx_core
    import uftx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] data_in,
    input  logic              par_en_in,
    input  logic              par_bit_in,
    input  logic              valid_in,
    output logic              line_out,
    output logic              busy_out
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

    typedef struct packed {
        tx_state_e         state;
        logic [DATA_W-1:0] shreg;
        logic [CNT_W-1:0]  idx;
        logic              par_bit;
        logic              par_en;
        logic              line;
        logic              busy;
    } core_regs_t;

    core_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                r_d.line = 1'b1;
                r_d.busy = 1'b0;
                if (valid_in) begin
                    r_d.shreg   = data_in;
                    r_d.par_bit = par_bit_in;
                    r_d.par_en  = par_en_in;
                    r_d.idx     = '0;
                    r_d.line    = 1'b0;
                    r_d.busy    = 1'b1;
                    r_d.state   = ST_START;
                end
            end
            ST_START: begin
                r_d.line  = r_q.shreg[0];
                r_d.shreg = r_q.shreg >> 1;
                r_d.idx   = '0;
                r_d.state = ST_DATA;
            end
            ST_DATA: begin
                if (r_q.idx == LAST_IDX) begin
                    if (r_q.par_en) begin
                        r_d.line  = r_q.par_bit;
                        r_d.state = ST_PAR;
                    end else begin
                        r_d.line  = 1'b1;
                        r_d.state = ST_STOP;
                    end
                end else begin
                    r_d.line  = r_q.shreg[0];
                    r_d.shreg = r_q.shreg >> 1;
                    r_d.idx   = r_q.idx + 1'b1;
                end
            end
            ST_PAR: begin
                r_d.line  = 1'b1;
                r_d.state = ST_STOP;
            end
            ST_STOP: begin
                r_d.line  = 1'b1;
                r_d.busy  = 1'b0;
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.line  = 1'b1;
                r_d.busy  = 1'b0;
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state   <= ST_IDLE;
            r_q.shreg   <= '0;
            r_q.idx     <= '0;
            r_q.par_bit <= 1'b0;
            r_q.par_en  <= 1'b0;
            r_q.line    <= 1'b1;
            r_q.busy    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign line_out = r_q.line;
    assign busy_out = r_q.busy;
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              par_on,
    input  logic              par_odd,
    input  logic              tx_valid,
    output logic              tx_line,
    output logic              tx_busy
);
    logic par_bit;

    uftx_parity #(.DATA_W(DATA_W)) u_par (
        .data    (tx_data),
        .odd     (par_odd),
        .bit_out (par_bit)
    );

    uftx_core #(.DATA_W(DATA_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .data_in    (tx_data),
        .par_en_in  (par_on),
        .par_bit_in (par_bit),
        .valid_in   (tx_valid),
        .line_out   (tx_line),
        .busy_out   (tx_busy)
    );
endmodule

// File: rtl/uftx_checker.sv
module uftx_checker #(
    parameter int DATA_W = 8
) (
    input logic clk,
    input logic rst,
    input logic tx_valid,
    input logic par_on,
    input logic tx_line,
    input logic tx_busy
);
    logic [15:0] busy_cnt;
    logic        cap_par;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt <= '0;
            cap_par  <= 1'b0;
        end else begin
            if (tx_busy) busy_cnt <= busy_cnt + 16'd1;
            else         busy_cnt <= '0;
            if (tx_valid && !tx_busy) cap_par <= par_on;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (tx_line && !tx_busy));

    p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> tx_line);

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_busy) |=> tx_busy);

    p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_busy) |-> !tx_line);

    p_stop_high_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_busy) |-> $past(tx_line));

    // R5 and R6: the busy window length follows the latched parity enable
    p_frame_len_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_busy) |-> (busy_cnt == (cap_par ? 16'(DATA_W + 3) : 16'(DATA_W + 2))));
endmodule

bind uart_frame_tx uftx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_valid (tx_valid),
    .par_on   (par_on),
    .tx_line  (tx_line),
    .tx_busy  (tx_busy)
);

// File: tb/uart_frame_tx_test.sv
`timescale 1ns/1ps
module uart_frame_tx_test;
    localparam int DW = 8;

    typedef struct {
        logic [DW+2:0] bits;
        int            n;
        logic          pe;
    } frame_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] tx_data = '0;
    logic          par_on = 1'b0;
    logic          par_odd = 1'b0;
    logic          tx_valid = 1'b0;
    logic          tx_line;
    logic          tx_busy;

    int     n_checks = 0;
    int     n_fails  = 0;
    frame_t expq[$];
    bit     done = 1'b0;

    always #2.5 clk = ~clk;

    uart_frame_tx #(.DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .tx_data(tx_data), .par_on(par_on),
        .par_odd(par_odd), .tx_valid(tx_valid), .tx_line(tx_line), .tx_busy(tx_busy)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic frame_t build(input logic [DW-1:0] d, input logic pe, input logic po);
        frame_t f;
        f.bits = '0;
        f.bits[0] = 1'b0;
        for (int i = 0; i < DW; i++) f.bits[1+i] = d[i];
        f.pe = pe;
        if (pe) begin
            f.bits[DW+1] = (^d) ^ po;
            f.bits[DW+2] = 1'b1;
            f.n = DW + 3;
        end else begin
            f.bits[DW+1] = 1'b1;
            f.n = DW + 2;
        end
        return f;
    endfunction

    // Driver: waits for idle, presents one strobe, queues the expected frame
    task automatic send(input logic [DW-1:0] d, input logic pe, input logic po);
        @(negedge clk);
        while (tx_busy) @(negedge clk);
        tx_data = d; par_on = pe; par_odd = po; tx_valid = 1'b1;
        expq.push_back(build(d, pe, po));
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    // Monitor: compares every line bit of each frame against the queue
    initial begin
        logic prev_busy;
        frame_t f;
        prev_busy = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst && tx_busy && !prev_busy) begin
                if (expq.size() == 0) begin
                    check("R8 unexpected frame", 1'b1, 1'b0);
                    f = build('0, 1'b0, 1'b0);
                end else begin
                    f = expq.pop_front();
                end
                check("R2 start bit", tx_line, 1'b0);
                for (int i = 1; i < f.n; i++) begin
                    @(negedge clk);
                    check("R6 busy in frame", tx_busy, 1'b1);
                    if (i <= DW)
                        check("R3 data bit", tx_line, f.bits[i]);
                    else if (f.pe && i == DW + 1)
                        check("R4 parity bit", tx_line, f.bits[i]);
                    else if (f.pe)
                        check("R6 stop bit", tx_line, f.bits[i]);
                    else
                        check("R5 stop after data", tx_line, f.bits[i]);
                end
                @(negedge clk);
                check("R6 busy low after stop", tx_busy, 1'b0);
                check("R1 idle line high", tx_line, 1'b1);
                prev_busy = tx_busy;
            end else begin
                prev_busy = tx_busy;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (tx_busy || expq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset line", tx_line, 1'b1);
        check("R1 reset busy", tx_busy, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 post-reset line", tx_line, 1'b1);
        check("R1 post-reset busy", tx_busy, 1'b0);

        // R3, R5: no parity, several patterns
        send(8'hA5, 1'b0, 1'b0);
        send(8'h01, 1'b0, 1'b1);
        send(8'h80, 1'b0, 1'b0);
        wait_idle();
        // R4: even and odd parity, odd and even weight data
        send(8'h3C, 1'b1, 1'b0);
        send(8'h3C, 1'b1, 1'b1);
        send(8'h07, 1'b1, 1'b0);
        send(8'h07, 1'b1, 1'b1);
        send(8'h00, 1'b1, 1'b0);
        send(8'hFF, 1'b1, 1'b1);
        wait_idle();

        // R7: change inputs during the frame
        send(8'h5A, 1'b1, 1'b0);
        tx_data = 8'hC3; par_on = 1'b0; par_odd = 1'b1;
        wait_idle();

        // R8: strobe while busy is ignored
        send(8'h96, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        tx_data = 8'h11; par_on = 1'b1; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        wait_idle();
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R8 no extra frame", tx_busy, 1'b0);
        end

        // R9: back-to-back acceptance leaves one idle cycle
        send(8'hF0, 1'b1, 1'b1);
        @(negedge clk);
        while (tx_busy) @(negedge clk);
        tx_data = 8'h0F; par_on = 1'b0; par_odd = 1'b0; tx_valid = 1'b1;
        expq.push_back(build(8'h0F, 1'b0, 1'b0));
        @(negedge clk);
        tx_valid = 1'b0;
        check("R9 back-to-back busy", tx_busy, 1'b1);
        check("R9 back-to-back start", tx_line, 1'b0);
        wait_idle();

        n_checks++;
        if (expq.size() != 0) begin
            n_fails++;
            $display("FAIL R2 frames pending: actual %0d expected 0", expq.size());
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule